// File: doc/BRIEF.md
# Strap-Addressed I2C Configuration Slave

This block lets a host microcontroller reach a bank of 8-bit configuration and status registers over a two-wire I2C bus. The block only ever acts as a slave. It samples SCL and SDA with a fast system clock and passes each line through a synchronizer and a counting spike filter. It then finds START, repeated START and STOP conditions and shifts bytes in on rising SCL edges. It pulls SDA low to acknowledge, and for bits it returns it either pulls SDA low or releases it.

The 7-bit device address is fixed at binary 011101 in its upper six bits. A strap input supplies the lowest bit. In a write, the first byte after the address loads an internal register pointer, and each later byte is written to the location the pointer names. A read always begins at the pointer, so a host can set the pointer with a write and read from it after a repeated START. The register bank itself sits outside the block. The block delivers a one-cycle write strobe with address and data, and it presents a read address whose data byte comes back combinationally.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The slave answers only to the 7-bit address {011101, addr_sel_i}, which is byte 0x74 or 0x76 for a write. It acknowledges that address byte by pulling SDA low during the ninth SCL pulse.
- R2: When the address does not match, the slave leaves SDA released for the ninth pulse and for every later bit. It issues no write strobe until the next START.
- R3: In a write, the first byte after the address loads the register pointer from its low AW bits. Each following byte produces exactly one single-cycle wr_en_o pulse, with wr_addr_o equal to the pointer and wr_data_o equal to the byte. After each such byte the pointer increments.
- R4: The register pointer wraps from 2**AW-1 to 0, both in writes and in reads.
- R5: A repeated START, with no STOP before it, is accepted as a new address phase. A read that follows it returns the byte at the pointer set by the preceding write.
- R6: A read returns bytes from consecutive addresses, MSB first. The pointer advances after each byte, so a later read session continues at the address after the last byte read.
- R7: A master NACK on a read byte ends the transfer. The slave releases SDA and drives no further bits until a START.
- R8: Every byte the slave receives after a matching address is acknowledged. The slave changes its SDA drive only while the filtered SCL is low.
- R9: A pulse on SCL or SDA shorter than FILT_LEN system clocks has no effect on a transfer. This covers a spurious SDA low pulse while SCL is high and a spurious SCL high pulse while SCL is low.
- R10: After a STOP, the slave is idle with SDA released. Bytes clocked without a new START are not acknowledged.
- R11: After reset, SDA is released and wr_en_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level, as seen on the wired bus |
| addr_sel_i | input | 1 | Strap selecting the lowest device address bit |
| sda_drive_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | AW | Register write address |
| wr_data_o | output | 8 | Register write data |
| rd_addr_o | output | AW | Register read address (current pointer) |
| rd_data_i | input | 8 | Register data for rd_addr_o |

## Verification
The bench builds the block with AW=4 and FILT_LEN=8. A 16-entry register space brings pointer wrap within reach of short bursts, and it allows every register to be written and read back in a single session. With the strap low, all 128 address values are swept, and both strap settings are exercised on their own matching addresses. Spikes of four system clocks, half the filter length, are placed on both lines in the middle of a live transfer, and the bench then shows that the transfer still lands correctly.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } xfer_state_e;

  typedef enum logic [1:0] {
    BY_DEV,
    BY_REG,
    BY_DATA
  } byte_kind_e;

  localparam logic [5:0] DEV_ADDR_HI = 6'b011101;

  // True when an address byte (7 address bits plus R/W) selects this slave.
  function automatic logic dev_addr_hit(input logic [7:0] addr_byte, input logic strap);
    return addr_byte[7:1] == {DEV_ADDR_HI, strap};
  endfunction

endpackage

// File: rtl/i2cs_glitch_filter.sv
module i2cs_glitch_filter #(
  parameter int FILT_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);
  localparam logic [CW-1:0] CNT_MAX = CW'(FILT_LEN - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  // A new level is taken only after it has held for FILT_LEN clocks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], din};
      if (sync_q[1] == dout) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_MAX) begin
        dout  <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_ev = scl & scl_q & sda_q & ~sda;
  assign stop_ev  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2cs_xfer_fsm.sv
module i2cs_xfer_fsm
  import i2cs_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          sda_in,
  input  logic          strap,
  input  logic [7:0]    rd_data,
  output logic          sda_low,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [AW-1:0] rd_addr,
  output logic          in_idle,
  output logic          nack_ev
);
  xfer_state_e   st_q;
  byte_kind_e    kind_q;
  logic [7:0]    rx_sh_q;
  logic [7:0]    tx_sh_q;
  logic [3:0]    bit_cnt_q;
  logic          rw_q;
  logic          mnack_q;
  logic [AW-1:0] ptr_q;

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return p + 1'b1;
  endfunction

  assign in_idle = (st_q == ST_IDLE);
  assign nack_ev = (st_q == ST_TXACK) && scl_fall && mnack_q;
  assign rd_addr = ptr_q;
  assign sda_low = (st_q == ST_RXACK) || ((st_q == ST_TX) && !tx_sh_q[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      kind_q    <= BY_DEV;
      rx_sh_q   <= '0;
      tx_sh_q   <= '1;
      bit_cnt_q <= '0;
      rw_q      <= 1'b0;
      mnack_q   <= 1'b0;
      ptr_q     <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_ev) begin
        st_q      <= ST_RX;
        kind_q    <= BY_DEV;
        bit_cnt_q <= '0;
      end else if (stop_ev) begin
        st_q <= ST_IDLE;
      end else begin
        unique case (st_q)
          ST_RX: begin
            if (scl_rise && bit_cnt_q != 4'd8) begin
              rx_sh_q   <= {rx_sh_q[6:0], sda_in};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall && bit_cnt_q == 4'd8) begin
              unique case (kind_q)
                BY_DEV: begin
                  if (dev_addr_hit(rx_sh_q, strap)) begin
                    rw_q <= rx_sh_q[0];
                    st_q <= ST_RXACK;
                  end else begin
                    st_q <= ST_IDLE;
                  end
                end
                BY_REG: begin
                  ptr_q <= rx_sh_q[AW-1:0];
                  st_q  <= ST_RXACK;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr_q;
                  wr_data <= rx_sh_q;
                  ptr_q   <= ptr_step(ptr_q);
                  st_q    <= ST_RXACK;
                end
              endcase
            end
          end
          ST_RXACK: begin
            if (scl_fall) begin
              bit_cnt_q <= '0;
              if (kind_q == BY_DEV && rw_q) begin
                st_q    <= ST_TX;
                tx_sh_q <= rd_data;
              end else begin
                st_q   <= ST_RX;
                kind_q <= (kind_q == BY_DEV) ? BY_REG : BY_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt_q == 4'd7) begin
                st_q      <= ST_TXACK;
                bit_cnt_q <= '0;
              end else begin
                tx_sh_q   <= {tx_sh_q[6:0], 1'b1};
                bit_cnt_q <= bit_cnt_q + 4'd1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              mnack_q <= sda_in;
              ptr_q   <= ptr_step(ptr_q);
            end else if (scl_fall) begin
              if (mnack_q) begin
                st_q <= ST_IDLE;
              end else begin
                st_q      <= ST_TX;
                tx_sh_q   <= rd_data;
                bit_cnt_q <= '0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave #(
  parameter int AW       = 8,
  parameter int FILT_LEN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          addr_sel_i,
  output logic          sda_drive_low_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] flt_lines;
  logic scl_flt, sda_flt;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic in_idle, nack_ev;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2cs_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_lines[g]),
      .dout (flt_lines[g])
    );
  end

  assign scl_flt = flt_lines[0];
  assign sda_flt = flt_lines[1];

  i2cs_bus_events u_events (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl     (scl_flt),
    .sda     (sda_flt),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  i2cs_xfer_fsm #(.AW(AW)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev),
    .sda_in  (sda_flt),
    .strap   (addr_sel_i),
    .rd_data (rd_data_i),
    .sda_low (sda_drive_low_o),
    .wr_en   (wr_en_o),
    .wr_addr (wr_addr_o),
    .wr_data (wr_data_o),
    .rd_addr (rd_addr_o),
    .in_idle (in_idle),
    .nack_ev (nack_ev)
  );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic clk,
  input logic rst_n,
  input logic sda_low,
  input logic wr_en,
  input logic scl_f,
  input logic start_ev,
  input logic in_idle,
  input logic nack_ev
);
  // R10: an idle slave never holds SDA.
  p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_low);

  // R3: each write strobe lasts a single cycle.
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R8: the SDA drive only moves while the filtered SCL is low.
  p_sda_move_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low) |-> !scl_f);

  // R5: a (repeated) START releases SDA for the new address phase.
  p_start_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_low);

  // R7: a master NACK returns the slave to idle.
  p_nack_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nack_ev |=> in_idle);
endmodule

bind i2c_cfg_slave i2cs_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sda_low (sda_drive_low_o),
  .wr_en   (wr_en_o),
  .scl_f   (scl_flt),
  .start_ev(start_ev),
  .in_idle (in_idle),
  .nack_ev (nack_ev)
);

// File: tb/i2c_cfg_slave_tb_top.sv
module i2c_cfg_slave_tb_top;
  localparam int AW   = 4;
  localparam int NREG = 1 << AW;
  localparam int FL   = 8;
  localparam int Q    = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, sad = 1'b0;
  logic sda_low, wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  wire  sda_bus = sda_m & ~sda_low;

  logic [7:0] regs [NREG];
  logic [7:0] expv [NREG];
  int wr_cnt = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_cfg_slave #(.AW(AW), .FILT_LEN(FL)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel_i(sad), .sda_drive_low_o(sda_low), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data));

  assign rd_data = regs[rd_addr];

  always @(posedge clk) if (wr_en) begin
    regs[wr_addr] <= wr_data;
    wr_cnt <= wr_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; q(); scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q();
  endtask

  task automatic bus_stop();
    sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q();
  endtask

  // glitch: 0 none, 1 SDA low spike while SCL high, 2 SCL high spike while SCL low
  task automatic send_byte(input logic [7:0] b, input int glitch, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      if (glitch == 2 && i == 3) begin
        repeat (4) @(negedge clk); scl_m = 1;
        repeat (4) @(negedge clk); scl_m = 0;
      end
      q(); scl_m = 1; q();
      if (glitch == 1 && b[i]) begin
        sda_m = 0; repeat (4) @(negedge clk); sda_m = 1;
      end
      q(); scl_m = 0; q();
    end
    sda_m = 1; q(); scl_m = 1; q(); ack = ~sda_bus; q(); scl_m = 0; q();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; q(); scl_m = 1; q(); b[i] = sda_bus; q(); scl_m = 0; q();
    end
    sda_m = ~mack; q(); scl_m = 1; q(); q(); scl_m = 0; q();
    sda_m = 1;
  endtask

  function automatic logic [7:0] pat(input int i, input int s);
    return 8'((i * 37 + s) & 8'h7F);   // MSB clear so a runaway read would pull SDA
  endfunction

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int w0, base;
    for (int i = 0; i < NREG; i++) begin regs[i] = 8'hFF; expv[i] = 8'hFF; end
    repeat (5) @(negedge clk);
    // R11: reset state
    check(sda_low == 0, "R11 sda released in reset", sda_low, 0);
    check(wr_en == 0, "R11 no strobe in reset", wr_en, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(sda_low == 0 && wr_en == 0, "R11 idle after reset", {sda_low, wr_en}, 0);

    // R1: full address sweep with strap low
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte(8'(a << 1), 0, ack);
      check(ack == (a == 58), "R1 address sweep", ack, (a == 58));
      bus_stop();
    end

    // R3 R4 R8: burst write of every register from 0, then wrap onto 0..1
    w0 = wr_cnt;
    bus_start();
    send_byte(8'h74, 0, ack); check(ack, "R8 ack address", ack, 1);
    send_byte(8'h00, 0, ack); check(ack, "R8 ack register byte", ack, 1);
    for (int i = 0; i < NREG + 2; i++) begin
      send_byte(pat(i, 5), 0, ack);
      expv[i % NREG] = pat(i, 5);
      check(ack, "R8 ack data byte", ack, 1);
    end
    bus_stop();
    // R10: idle after STOP
    check(sda_low == 0, "R10 released after stop", sda_low, 0);
    check(wr_cnt - w0 == NREG + 2, "R3 one strobe per data byte", wr_cnt - w0, NREG + 2);
    for (int i = 0; i < NREG; i++)
      check(regs[i] == expv[i], "R3 R4 register contents", regs[i], expv[i]);

    // R5 R6 R4: set pointer to 14, repeated START, read 6 bytes wrapping
    base = NREG - 2;
    bus_start();
    send_byte(8'h74, 0, ack);
    send_byte(8'(base), 0, ack);
    bus_start();
    send_byte(8'h75, 0, ack); check(ack, "R5 ack read address after repeated start", ack, 1);
    for (int i = 0; i < 6; i++) begin
      recv_byte(i != 5, b);
      check(b == expv[(base + i) % NREG], "R5 R4 read data", b, expv[(base + i) % NREG]);
    end
    // R7: after NACK the slave stays off the bus (next byte has MSB 0)
    repeat (4 * Q) @(negedge clk);
    check(sda_low == 0, "R7 released after master nack", sda_low, 0);
    scl_m = 1; q(); q();
    check(sda_bus == 1, "R7 no bit driven after nack", sda_bus, 1);
    scl_m = 0; q();
    bus_stop();

    // R6: new session continues after the last byte read
    bus_start();
    send_byte(8'h75, 0, ack);
    for (int i = 0; i < 2; i++) begin
      recv_byte(i == 0, b);
      check(b == expv[(base + 6 + i) % NREG], "R6 read continues across sessions", b,
            expv[(base + 6 + i) % NREG]);
    end
    bus_stop();

    // R2: mismatching address, following bytes ignored
    w0 = wr_cnt;
    bus_start();
    send_byte(8'h76, 0, ack); check(!ack, "R2 no ack on mismatch", ack, 0);
    send_byte(8'h03, 0, ack); check(!ack, "R2 no ack after mismatch", ack, 0);
    send_byte(8'h11, 0, ack); check(!ack, "R2 no ack data after mismatch", ack, 0);
    bus_stop();
    check(wr_cnt == w0, "R2 no write after mismatch", wr_cnt - w0, 0);

    // R10: bytes without START are not acknowledged
    send_byte(8'h74, 0, ack); check(!ack, "R10 no ack without start", ack, 0);
    bus_stop();

    // R1: strap high moves the address to 0x76
    sad = 1;
    repeat (4) @(negedge clk);
    bus_start();
    send_byte(8'h74, 0, ack); check(!ack, "R1 strap high rejects 0x74", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'h76, 0, ack); check(ack, "R1 strap high accepts 0x76", ack, 1);
    send_byte(8'h03, 0, ack);
    send_byte(8'h5A, 0, ack);
    bus_stop();
    expv[3] = 8'h5A;
    check(regs[3] == 8'h5A, "R1 R3 write with strap high", regs[3], 8'h5A);

    // R9: spikes on SDA and SCL within a live write
    w0 = wr_cnt;
    bus_start();
    send_byte(8'h76, 1, ack); check(ack, "R9 ack despite SDA spike", ack, 1);
    send_byte(8'h07, 2, ack); check(ack, "R9 ack despite SCL spike", ack, 1);
    send_byte(8'h3C, 1, ack); check(ack, "R9 ack data with SDA spike", ack, 1);
    bus_stop();
    check(regs[7] == 8'h3C, "R9 data landed at right register", regs[7], 8'h3C);
    check(wr_cnt - w0 == 1, "R9 single strobe", wr_cnt - w0, 1);

    done = 1;
    finish_run();
  end
endmodule